// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor and Power-Good Encoder

This block supervises a synchronous buck converter from digitized comparator outputs. It qualifies current-limit samples that arrive once per switching pulse. It latches the converter off on overcurrent, short-circuit, overvoltage or undervoltage. It suspends switching while the die is hot. It also reports the cause of a shutdown as a two-bit pull-down strength code that drives a power-good output stage. Each fault has its own clearing rule. Current-limit and undervoltage latches release when the enable input drops. The overvoltage latch releases only when the supply monitor reports loss of supply.

The controller is one state register with seven states: ST_OFF (supply not good), ST_IDLE (supply good, converter disabled), ST_RUN, ST_HOT (thermal suspend), and three latched states: ST_LOCK_OC, ST_LOCK_OV and ST_LOCK_UV. The transitions are:
- supply loss, from any state, to ST_OFF.
- supply good: ST_OFF to ST_IDLE.
- enable: ST_IDLE to ST_RUN.
- disable: ST_RUN, ST_HOT, ST_LOCK_OC or ST_LOCK_UV to ST_IDLE.
- current trip: ST_RUN or ST_HOT to ST_LOCK_OC.
- overvoltage: ST_RUN or ST_HOT to ST_LOCK_OV.
- undervoltage: ST_RUN or ST_HOT to ST_LOCK_UV.
- hot: ST_RUN to ST_HOT.
- cool: ST_HOT to ST_RUN.

While the overvoltage latch is held, a small clamp register still switches the low-side gate on and off with the output level.

The qualification windows are counted in clock ticks and derived from the CLK_HZ parameter. The overcurrent window is CLK_HZ/50000 ticks (20 µs). The short-circuit window is half of that (10 µs).

Top module: `fault_supervisor`

## Requirements
- R1: While the asynchronous reset is active, or the supply monitor is low, the block is in ST_OFF. pg_undef is 1, pg_code is 2'b00, latch_off is 0, and hs_force_low and ls_force_low are both 1. One clock edge with supply_ok low is enough to reach ST_OFF from any state.
- R2: With the supply good and en low, the block is in ST_IDLE: pg_code 2'b01, both gates forced low, latch_off 0. One edge after en rises it is in ST_RUN: pg_code 2'b00 and no gate forced.
- R3: oc_flag is sampled only in a cycle where cur_stb is 1. The first high sample arms a counter. If no low sample arrives for CLK_HZ/50000 clock ticks, the block enters ST_LOCK_OC: latch_off 1, pg_code 2'b11, both gates forced low.
- R4: A strobed low sample of oc_flag disarms and clears the counter, so a new window starts from the next high sample. oc_flag held high with cur_stb low never trips.
- R5: sc_flag is qualified in the same way with a window of CLK_HZ/100000 ticks, and it leads to the same ST_LOCK_OC state and code 2'b11.
- R6: ST_LOCK_OC and ST_LOCK_UV release to ST_IDLE (pg_code 2'b01, latch_off 0) one edge after en falls. Raising en again returns to ST_RUN with pg_code 2'b00.
- R7: fb_over_hi high in ST_RUN or ST_HOT enters ST_LOCK_OV: latch_off 1, pg_code 2'b10, hs_force_low 1. Dropping en does not release it. Only supply_ok low does.
- R8: In ST_LOCK_OV, ls_force_on is set on an edge where fb_over_hi is high. It is cleared on an edge where fb_over_lo is low, and it holds otherwise. ls_force_on and ls_force_low are never both 1, and ls_force_on is 0 in every other state.
- R9: fb_under high in ST_RUN enters ST_LOCK_UV: latch_off 1, pg_code 2'b01, both gates forced low.
- R10: temp_hot in ST_RUN enters ST_HOT. Both gates are forced low, latch_off stays 0 and pg_code stays 2'b00. temp_cool returns to ST_RUN, and en low goes to ST_IDLE.
- R11: Every latching fault is still detected in ST_HOT. An undervoltage there enters ST_LOCK_UV with code 2'b01.
- R12: The first latched fault fixes pg_code. Later fault flags change neither pg_code nor latch_off until the latch is released. When flags arrive in the same cycle, the priority is current trip, then overvoltage, then undervoltage, then over-temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply monitor: bias supply above its threshold |
| en | input | 1 | Converter enable |
| cur_stb | input | 1 | Current-sample strobe, one cycle per pulse, shortly after the low-side gate turns on |
| oc_flag | input | 1 | Sensed current above the overcurrent threshold |
| sc_flag | input | 1 | Sensed current above twice the overcurrent threshold |
| fb_over_hi | input | 1 | Feedback above 116 % of reference |
| fb_over_lo | input | 1 | Feedback above 103 % of reference |
| fb_under | input | 1 | Feedback below 84 % of reference |
| temp_hot | input | 1 | Die temperature above the 150 °C trip |
| temp_cool | input | 1 | Die temperature back below trip minus 25 °C |
| latch_off | output | 1 | Converter latched off by a fault |
| hs_force_low | output | 1 | Hold the high-side gate low |
| ls_force_low | output | 1 | Hold the low-side gate low |
| ls_force_on | output | 1 | Drive the low-side gate on (overvoltage clamp) |
| pg_code | output | 2 | Power-good pull-down strength: 00 released, 01 95 Ω, 10 60 Ω, 11 30 Ω |
| pg_undef | output | 1 | Power-good state undefined (supply not good) |

## Verification
Overvoltage, undervoltage and over-temperature flags can all be presented in the same cycle in which the converter is running. The block must then pick one latched state and one pull-down code by priority. The bench draws random combinations of these three flags with a fixed seed and raises them together for one cycle from ST_RUN. It then compares pg_code, latch_off and the high-side force against a bench function that encodes the priority. Directed cases add a late fault arriving onto an existing latch. They also add a thermal suspend followed by an undervoltage trip.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_RUN     = 3'd2,
        ST_HOT     = 3'd3,
        ST_LOCK_OC = 3'd4,
        ST_LOCK_OV = 3'd5,
        ST_LOCK_UV = 3'd6
    } fsup_state_e;

    typedef enum logic [1:0] {
        PG_RELEASE = 2'b00,
        PG_WEAK    = 2'b01,
        PG_MID     = 2'b10,
        PG_STRONG  = 2'b11
    } pg_code_e;

    localparam int unsigned N_QUAL  = 2;
    localparam int unsigned QUAL_OC = 0;
    localparam int unsigned QUAL_SC = 1;

endpackage

// File: rtl/fsup_qualifier.sv
module fsup_qualifier #(
    parameter int unsigned WIN_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic flag,
    output logic trip
);

    localparam int unsigned CW = $clog2(WIN_TICKS + 1);
    localparam logic [CW-1:0] CNT_END = CW'(WIN_TICKS);

    logic          armed;
    logic [CW-1:0] cnt;

    // a strobed low sample or a clear disarms; the first strobed high sample arms
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (clr || (stb && !flag)) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (stb && flag && !armed) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && (cnt != CNT_END)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign trip = armed && (cnt == CNT_END);

endmodule

// File: rtl/fsup_ov_clamp.sv
module fsup_ov_clamp (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic over_hi,
    input  logic over_lo,
    output logic ls_on
);

    // hysteretic low-side control while the overvoltage latch holds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_on <= 1'b0;
        end else if (!active) begin
            ls_on <= 1'b0;
        end else if (over_hi) begin
            ls_on <= 1'b1;
        end else if (!over_lo) begin
            ls_on <= 1'b0;
        end
    end

endmodule

// File: rtl/fsup_out_decode.sv
module fsup_out_decode
    import fsup_pkg::*;
(
    input  fsup_state_e st,
    input  logic        clamp_on,
    output logic        latch_off,
    output logic        hs_force_low,
    output logic        ls_force_low,
    output logic        ls_force_on,
    output logic [1:0]  pg_code,
    output logic        pg_undef
);

    always_comb begin
        latch_off    = 1'b0;
        hs_force_low = 1'b1;
        pg_undef     = 1'b0;
        pg_code      = PG_RELEASE;
        unique case (st)
            ST_OFF:     pg_undef = 1'b1;
            ST_IDLE:    pg_code = PG_WEAK;
            ST_RUN:     hs_force_low = 1'b0;
            ST_HOT:     pg_code = PG_RELEASE;
            ST_LOCK_OC: begin latch_off = 1'b1; pg_code = PG_STRONG; end
            ST_LOCK_OV: begin latch_off = 1'b1; pg_code = PG_MID;    end
            ST_LOCK_UV: begin latch_off = 1'b1; pg_code = PG_WEAK;   end
            default:    pg_undef = 1'b1;
        endcase
        ls_force_on  = clamp_on && (st == ST_LOCK_OV);
        ls_force_low = hs_force_low && !ls_force_on;
    end

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       en,
    input  logic       cur_stb,
    input  logic       oc_flag,
    input  logic       sc_flag,
    input  logic       fb_over_hi,
    input  logic       fb_over_lo,
    input  logic       fb_under,
    input  logic       temp_hot,
    input  logic       temp_cool,
    output logic       latch_off,
    output logic       hs_force_low,
    output logic       ls_force_low,
    output logic       ls_force_on,
    output logic [1:0] pg_code,
    output logic       pg_undef
);

    localparam int unsigned OC_TICKS = (CLK_HZ / 50_000 > 1) ? CLK_HZ / 50_000 : 2;
    localparam int unsigned SC_TICKS = OC_TICKS / 2;

    fsup_state_e          state, nxt;
    logic [N_QUAL-1:0]    q_flag, q_trip;
    logic                 q_clr;
    logic                 clamp_on;

    assign q_flag = {sc_flag, oc_flag};
    assign q_clr  = !((state == ST_RUN) || (state == ST_HOT));

    for (genvar g = 0; g < N_QUAL; g++) begin : g_qual
        localparam int unsigned WIN = (g == QUAL_OC) ? OC_TICKS : SC_TICKS;
        fsup_qualifier #(.WIN_TICKS(WIN)) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (q_clr),
            .stb  (cur_stb),
            .flag (q_flag[g]),
            .trip (q_trip[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // next state: supply loss dominates, then per-state rules
    always_comb begin
        nxt = state;
        if (!supply_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_IDLE;
                ST_IDLE: nxt = en ? ST_RUN : ST_IDLE;
                ST_RUN, ST_HOT: begin
                    if (!en)                                nxt = ST_IDLE;
                    else if (|q_trip)                       nxt = ST_LOCK_OC;
                    else if (fb_over_hi)                    nxt = ST_LOCK_OV;
                    else if (fb_under)                      nxt = ST_LOCK_UV;
                    else if ((state == ST_RUN) && temp_hot) nxt = ST_HOT;
                    else if ((state == ST_HOT) && temp_cool) nxt = ST_RUN;
                end
                ST_LOCK_OC, ST_LOCK_UV: nxt = en ? state : ST_IDLE;
                ST_LOCK_OV: nxt = ST_LOCK_OV;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    fsup_ov_clamp u_clamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_LOCK_OV),
        .over_hi(fb_over_hi),
        .over_lo(fb_over_lo),
        .ls_on  (clamp_on)
    );

    fsup_out_decode u_dec (
        .st          (state),
        .clamp_on    (clamp_on),
        .latch_off   (latch_off),
        .hs_force_low(hs_force_low),
        .ls_force_low(ls_force_low),
        .ls_force_on (ls_force_on),
        .pg_code     (pg_code),
        .pg_undef    (pg_undef)
    );

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       en,
    input logic       latch_off,
    input logic       hs_force_low,
    input logic       ls_force_low,
    input logic       ls_force_on,
    input logic [1:0] pg_code,
    input logic       pg_undef
);

    // R1
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_undef |-> (pg_code == 2'b00) && !latch_off && hs_force_low);

    // R7
    supply_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> pg_undef && !latch_off);

    // R8
    ls_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_force_on && ls_force_low));

    // R8
    ls_clamp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_force_on |-> (pg_code == 2'b10) && hs_force_low);

    // R12
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_off && en && supply_ok) |=> latch_off);

    // R12
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_off && en && supply_ok) |=> $stable(pg_code));

    // R3
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_off |-> hs_force_low);

endmodule

bind fault_supervisor fsup_checker u_fsup_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .en          (en),
    .latch_off   (latch_off),
    .hs_force_low(hs_force_low),
    .ls_force_low(ls_force_low),
    .ls_force_on (ls_force_on),
    .pg_code     (pg_code),
    .pg_undef    (pg_undef)
);

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;

    logic       clk = 1'b0;
    logic       rst_n, supply_ok, en, cur_stb, oc_flag, sc_flag;
    logic       fb_over_hi, fb_over_lo, fb_under, temp_hot, temp_cool;
    logic       latch_off, hs_force_low, ls_force_low, ls_force_on, pg_undef;
    logic [1:0] pg_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    // 5 MHz view: overcurrent window 100 ticks, short-circuit window 50 ticks
    fault_supervisor #(.CLK_HZ(5_000_000)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en(en),
        .cur_stb(cur_stb), .oc_flag(oc_flag), .sc_flag(sc_flag),
        .fb_over_hi(fb_over_hi), .fb_over_lo(fb_over_lo), .fb_under(fb_under),
        .temp_hot(temp_hot), .temp_cool(temp_cool),
        .latch_off(latch_off), .hs_force_low(hs_force_low),
        .ls_force_low(ls_force_low), .ls_force_on(ls_force_on),
        .pg_code(pg_code), .pg_undef(pg_undef)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        cur_stb = 0; oc_flag = 0; sc_flag = 0; fb_over_hi = 0; fb_over_lo = 0;
        fb_under = 0; temp_hot = 0; temp_cool = 0;
    endtask

    task automatic restart();
        clear_flags();
        supply_ok = 0; en = 0;
        step(2);
        supply_ok = 1; en = 1;
        step(3);
    endtask

    task automatic strobes(input int n, input bit oc, input bit sc);
        for (int i = 0; i < n; i++) begin
            cur_stb = 1; oc_flag = oc; sc_flag = sc;
            step(1);
            cur_stb = 0;
            step(9);
        end
    endtask

    function automatic logic [1:0] exp_code(input bit ov, input bit uv);
        return ov ? 2'b10 : (uv ? 2'b01 : 2'b00);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        clear_flags();
        rst_n = 0; supply_ok = 0; en = 0;
        step(3);
        // R1 reset state
        check("R1 undef", pg_undef, 1);
        check("R1 code", pg_code, 0);
        check("R1 latch", latch_off, 0);
        check("R1 hs", hs_force_low, 1);
        check("R1 ls", ls_force_low, 1);
        rst_n = 1; supply_ok = 1;
        step(2);
        // R2 idle
        check("R2 idle code", pg_code, 1);
        check("R2 idle hs", hs_force_low, 1);
        en = 1; step(1);
        check("R2 run code", pg_code, 0);
        check("R2 run hs", hs_force_low, 0);
        check("R2 run ls", ls_force_low, 0);

        // R4 flag without strobe
        restart();
        oc_flag = 1; step(150);
        check("R4 no strobe", latch_off, 0);
        // R3 qualified trip
        restart();
        strobes(9, 1, 0);
        check("R3 before window", latch_off, 0);
        strobes(3, 1, 0);
        check("R3 latch", latch_off, 1);
        check("R3 code", pg_code, 3);
        check("R3 gates", ls_force_low, 1);
        // R4 low sample restarts window
        restart();
        strobes(5, 1, 0);
        strobes(1, 0, 0);
        strobes(8, 1, 0);
        check("R4 restart", latch_off, 0);

        // R5 short circuit
        restart();
        strobes(4, 0, 1);
        check("R5 before window", latch_off, 0);
        strobes(3, 0, 1);
        check("R5 latch", latch_off, 1);
        check("R5 code", pg_code, 3);
        // R6 release on enable low
        en = 0; step(2);
        check("R6 released code", pg_code, 1);
        check("R6 released latch", latch_off, 0);
        en = 1; step(2);
        check("R6 rerun", pg_code, 0);

        // R9 undervoltage, then R12 late fault
        restart();
        fb_under = 1; step(1); fb_under = 0; step(1);
        check("R9 latch", latch_off, 1);
        check("R9 code", pg_code, 1);
        fb_over_hi = 1; fb_over_lo = 1; step(2);
        check("R12 code held", pg_code, 1);
        check("R12 no clamp", ls_force_on, 0);
        fb_over_hi = 0; fb_over_lo = 0;
        en = 0; step(2);
        check("R6 uv released", latch_off, 0);

        // R7 and R8 overvoltage
        restart();
        fb_over_hi = 1; fb_over_lo = 1; step(2);
        check("R7 latch", latch_off, 1);
        check("R7 code", pg_code, 2);
        check("R8 on", ls_force_on, 1);
        check("R8 on low", ls_force_low, 0);
        check("R7 hs", hs_force_low, 1);
        fb_over_hi = 0; step(2);
        check("R8 hold", ls_force_on, 1);
        fb_over_lo = 0; step(2);
        check("R8 off", ls_force_on, 0);
        check("R8 off low", ls_force_low, 1);
        fb_over_hi = 1; fb_over_lo = 1; step(2);
        check("R8 again", ls_force_on, 1);
        fb_over_hi = 0; fb_over_lo = 0;
        en = 0; step(3);
        check("R7 en ignored", latch_off, 1);
        check("R7 en code", pg_code, 2);
        supply_ok = 0; step(1);
        check("R7 supply clears", pg_undef, 1);
        check("R7 supply latch", latch_off, 0);

        // R10 over-temperature
        restart();
        temp_hot = 1; step(1); temp_hot = 0; step(1);
        check("R10 hs", hs_force_low, 1);
        check("R10 ls", ls_force_low, 1);
        check("R10 latch", latch_off, 0);
        check("R10 code", pg_code, 0);
        temp_cool = 1; step(1); temp_cool = 0; step(1);
        check("R10 resume", hs_force_low, 0);
        temp_hot = 1; step(1); temp_hot = 0;
        en = 0; step(1);
        check("R10 en idle", pg_code, 1);
        en = 1; step(2);
        check("R10 en rerun", hs_force_low, 0);
        // R11 undervoltage during thermal suspend
        temp_hot = 1; step(1); temp_hot = 0;
        fb_under = 1; step(1); fb_under = 0; step(1);
        check("R11 latch", latch_off, 1);
        check("R11 code", pg_code, 1);

        // R12 same-cycle priority, random combinations
        for (int k = 0; k < 30; k++) begin
            bit ov, uv, hot;
            ov = 1'($urandom % 2); uv = 1'($urandom % 2); hot = 1'($urandom % 2);
            restart();
            fb_over_hi = ov; fb_over_lo = ov; fb_under = uv; temp_hot = hot;
            step(1);
            clear_flags();
            step(1);
            check("R12 prio code", pg_code, exp_code(ov, uv));
            check("R12 prio latch", latch_off, ov | uv);
            check("R12 prio hs", hs_force_low, ov | uv | hot);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule